// File: doc/BRIEF.md
# Watchdog Timer with Selectable Reset Target

This block is a software-serviced watchdog. Firmware programs a 16-bit reload value, a 4-bit rate selector and an enable bit through a small byte-wide register port. Once armed, a down-counter starts from the reload value and steps down once every 2^N pulses of a 1 MHz enable input, where N is the rate selector. Firmware must write the kick register often enough to restart the count. If the count runs out, the block emits a one-clock reset request and then starts a new period from the reload value.

A steering bit in the control register picks where the timeout goes: a reset of the local board only, or a system reset driven onto the backplane. When the board acts as the system controller, a local reset also produces a backplane system reset. Clock generation, stretching the reset pulses to backplane timing, and the backplane drivers are outside this block.

All register writes take one cycle and are never stalled. Reads are combinational from the address, and the block has no read strobe.

Top module: `wdt_rst_sel`

## Requirements
- R1: After reset, both reset outputs are low, the control register reads 0x00, the rate register reads 0x00, and the reload value reads 0x03FF.
- R2: The register addresses are 0 kick, 1 control (bit 0 enable, bit 1 target select), 2 rate (bits 3:0), 3 reload bits 7:0, and 4 reload bits 15:8. Control bits 7:2, rate bits 7:4, the kick register and any unused address read 0, and writes to reserved bits have no effect.
- R3: A control write that sets enable while the block is disabled loads the counter from the reload value and restarts the rate prescaler. With us_tick high every cycle and N=0, a reset pulse is visible C cycles after the arming write, where C is the reload value.
- R4: Every write to address 0 loads the counter from the reload value and restarts the prescaler, whatever data is written. Kicks repeated more often than the timeout period keep both outputs low.
- R5: While enabled, the counter steps down by one on each 2^N-th us_tick pulse. A write to the rate register restarts the prescaler, and no step happens in that cycle. The spacing between timeouts is max(C,1)·2^N us_tick pulses.
- R6: A step taken while the counter holds 1 or 0 is a timeout. The counter then reloads and keeps running, and the selected output is high for exactly the one cycle that follows that step.
- R7: If the target bit is 0, a timeout pulses board_rst. If it is 1, a timeout pulses bp_sysrst and leaves board_rst low.
- R8: If the target bit is 0 and sys_ctrl is high, a timeout pulses board_rst and bp_sysrst in the same cycle.
- R9: While enable is 0, the counter does not step and neither output pulses. A reload value written while the counter runs takes effect only at the next load.
- R10: A kick in the same cycle as a timeout step wins: the counter reloads and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse at 1 MHz that drives the prescaler |
| sys_ctrl | input | 1 | High when this board is the system controller |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| board_rst | output | 1 | One-cycle board reset request |
| bp_sysrst | output | 1 | One-cycle backplane system reset request |

## Verification
The hardest case to reach is a kick that arrives on the exact clock edge where the terminal step would happen. That edge depends on the phase of us_tick, the prescaler state and the counter, none of which is visible at the ports. The bench drives us_tick on every cycle and keeps the reload small so that timeouts repeat with a fixed cycle period. It waits for one pulse, then places a kick so that it is sampled on the next terminal edge, and checks that the following pulse comes one full period after the kick. A behavioural model that runs alongside on every clock covers the other orderings: rate writes, disable writes and reload changes made while the counter runs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BUS_AW = 3;
  localparam int BUS_DW = 8;

  localparam logic [BUS_AW-1:0] A_KICK = 3'd0;
  localparam logic [BUS_AW-1:0] A_CTRL = 3'd1;
  localparam logic [BUS_AW-1:0] A_RATE = 3'd2;
  localparam logic [BUS_AW-1:0] A_RLD0 = 3'd3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SEL_BIT = 1;

  // strobes decoded from one bus write
  typedef struct packed {
    logic kick;   // load counter
    logic arm;    // enable 0 -> 1
    logic halt;   // control write clearing enable
    logic rate;   // rate register written
  } wdt_evt_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter int          RES_W   = 4,
  parameter logic [CNT_W-1:0] CNT_RST = 16'h03FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              en_q,
  output logic              sel_q,
  output logic [RES_W-1:0]  res_q,
  output logic [CNT_W-1:0]  reload,
  output wdt_evt_t          evt
);
  localparam int NB = CNT_W / BUS_DW;

  logic [NB-1:0][BUS_DW-1:0] rld_q;
  logic [NB-1:0]             rld_hit;
  logic                      ctrl_wr;

  for (genvar b = 0; b < NB; b++) begin : g_rld_dec
    assign rld_hit[b] = bus_wr && (bus_addr == A_RLD0 + BUS_AW'(b));
  end

  assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
  assign evt.kick  = bus_wr && (bus_addr == A_KICK);
  assign evt.rate  = bus_wr && (bus_addr == A_RATE);
  assign evt.arm   = ctrl_wr && bus_wdata[CTRL_EN_BIT] && !en_q;
  assign evt.halt  = ctrl_wr && !bus_wdata[CTRL_EN_BIT];
  assign reload    = rld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      res_q <= '0;
      rld_q <= CNT_RST;
    end else begin
      if (ctrl_wr) begin
        en_q  <= bus_wdata[CTRL_EN_BIT];
        sel_q <= bus_wdata[CTRL_SEL_BIT];
      end
      if (evt.rate) res_q <= bus_wdata[RES_W-1:0];
      for (int b = 0; b < NB; b++) begin
        if (rld_hit[b]) rld_q[b] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[CTRL_EN_BIT]  = en_q;
      bus_rdata[CTRL_SEL_BIT] = sel_q;
    end else if (bus_addr == A_RATE) begin
      bus_rdata[RES_W-1:0] = res_q;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (bus_addr == A_RLD0 + BUS_AW'(b)) bus_rdata = rld_q[b];
      end
    end
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
#(
  parameter int RES_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  wdt_evt_t         evt,
  input  logic             us_tick,
  input  logic [RES_W-1:0] res_q,
  output logic             step
);
  localparam int PRE_W = (1 << RES_W) - 1;
  localparam logic [PRE_W-1:0] ONES = '1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic [RES_W-1:0] sh;
  logic             run;
  logic             clr;

  assign run  = en_q && !evt.halt && !evt.rate;
  assign clr  = evt.kick || evt.arm || evt.rate || evt.halt || !en_q;
  assign sh   = RES_W'(PRE_W) - res_q;
  assign mask = ONES >> sh;
  assign step = run && us_tick && (pre_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
    end else if (run && us_tick) begin
      pre_q <= (pre_q == mask) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] CNT_RST = 16'h03FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  wdt_evt_t         evt,
  input  logic             sel_q,
  input  logic             sys_ctrl,
  input  logic [CNT_W-1:0] reload,
  output logic             board_rst,
  output logic             bp_sysrst
);
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic             load;

  assign load   = evt.kick || evt.arm;
  assign expire = step && !load && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_RST;
      board_rst <= 1'b0;
      bp_sysrst <= 1'b0;
    end else begin
      if (load || expire) cnt_q <= reload;
      else if (step)      cnt_q <= cnt_q - 1'b1;
      board_rst <= expire && !sel_q;
      bp_sysrst <= expire && (sel_q || sys_ctrl);
    end
  end
endmodule

// File: rtl/wdt_rst_sel.sv
module wdt_rst_sel
  import wdt_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter int               RES_W   = 4,
  parameter logic [CNT_W-1:0] CNT_RST = 16'h03FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        sys_ctrl,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        board_rst,
  output logic        bp_sysrst
);
  logic             en_q;
  logic             sel_q;
  logic [RES_W-1:0] res_q;
  logic [CNT_W-1:0] reload;
  wdt_evt_t         evt;
  logic             step;

  wdt_regs #(.CNT_W(CNT_W), .RES_W(RES_W), .CNT_RST(CNT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_q(en_q),
    .sel_q(sel_q), .res_q(res_q), .reload(reload), .evt(evt)
  );

  wdt_prescale #(.RES_W(RES_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .evt(evt),
    .us_tick(us_tick), .res_q(res_q), .step(step)
  );

  wdt_core #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .evt(evt), .sel_q(sel_q),
    .sys_ctrl(sys_ctrl), .reload(reload), .board_rst(board_rst),
    .bp_sysrst(bp_sysrst)
  );
endmodule

// File: rtl/wdt_rst_sel_chk.sv
module wdt_rst_sel_chk
  import wdt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sys_ctrl,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic       board_rst,
  input logic       bp_sysrst,
  input logic       en_q,
  input logic       sel_q
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[7:2] == 6'd0));

  a_r7_board_local_only: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst |-> !$past(sel_q));

  a_r7_bp_source: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_sysrst && !$past(sys_ctrl)) |-> $past(sel_q));

  a_r8_sysctrl_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (board_rst && $past(sys_ctrl)) |-> bp_sysrst);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_q) |-> !(board_rst || bp_sysrst));

  a_r10_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && (bus_addr == A_KICK)) |-> !(board_rst || bp_sysrst));
endmodule

bind wdt_rst_sel wdt_rst_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_ctrl(sys_ctrl), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .board_rst(board_rst),
  .bp_sysrst(bp_sysrst), .en_q(en_q), .sel_q(sel_q)
);

// File: tb/wdt_rst_sel_test.sv
module wdt_rst_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       sys_ctrl = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       board_rst;
  logic       bp_sysrst;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tick_div = 0;
  int tphase = 0;

  always #10 clk = ~clk;

  wdt_rst_sel uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .sys_ctrl(sys_ctrl),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .board_rst(board_rst), .bp_sysrst(bp_sysrst)
  );

  // us_tick source: one pulse every tick_div cycles
  always @(negedge clk) begin
    if (tick_div == 0) us_tick <= 1'b0;
    else begin
      tphase = (tphase + 1) % tick_div;
      us_tick <= (tphase == 0);
    end
  end

  // behavioural reference model
  logic [15:0] m_rld = 16'h03FF;
  int  m_cnt = 16'h03FF;
  int  m_pre = 0;
  int  m_res = 0;
  bit  m_en = 0, m_sel = 0, m_board = 0, m_bp = 0;

  always @(posedge clk) begin
    bit wl, wc, wrt, tk, nen, fire;
    if (!rst_n) begin
      m_rld = 16'h03FF; m_cnt = 16'h03FF; m_pre = 0; m_res = 0;
      m_en = 0; m_sel = 0; m_board = 0; m_bp = 0;
    end else begin
      wl  = bus_wr && bus_addr == 3'd0;
      wc  = bus_wr && bus_addr == 3'd1;
      wrt = bus_wr && bus_addr == 3'd2;
      tk = 0; fire = 0;
      nen = wc ? bus_wdata[0] : m_en;
      if (m_en && nen && us_tick && !wrt) begin
        if (m_pre == (1 << m_res) - 1) begin tk = 1; m_pre = 0; end
        else m_pre++;
      end
      if (wl || (wc && bus_wdata[0] && !m_en)) begin
        m_cnt = m_rld; m_pre = 0;
      end else if (tk) begin
        if (m_cnt <= 1) begin fire = 1; m_cnt = m_rld; end
        else m_cnt--;
      end
      if (!nen || wrt) m_pre = 0;
      m_board = fire && !m_sel;
      m_bp    = fire && (m_sel || sys_ctrl);
      if (wc) begin m_en = nen; m_sel = bus_wdata[1]; end
      if (wrt) m_res = bus_wdata[3:0];
      if (bus_wr && bus_addr == 3'd3) m_rld[7:0]  = bus_wdata;
      if (bus_wr && bus_addr == 3'd4) m_rld[15:8] = bus_wdata;
    end
  end

  function automatic int exp_rd(input logic [2:0] a);
    case (a)
      3'd1: return {m_sel, m_en};
      3'd2: return m_res;
      3'd3: return m_rld[7:0];
      3'd4: return m_rld[15:8];
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the edge
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      chk("R6/R7 board_rst vs model", board_rst, m_board);
      chk("R7/R8 bp_sysrst vs model", bp_sysrst, m_bp);
      chk("R2 bus_rdata vs model", bus_rdata, exp_rd(bus_addr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'd0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    @(negedge clk);
    bus_addr = a;
    #5;
    chk(tag, bus_rdata, exp);
  endtask

  // which: 0 board, 1 backplane, 2 both together
  task automatic wait_pulse(input int which, input int limit, output int k, output int wrong);
    k = -1; wrong = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk); #5;
      if (which == 0 && bp_sysrst) wrong++;
      if (which == 1 && board_rst) wrong++;
      if ((which == 0 && board_rst) || (which == 1 && bp_sysrst) ||
          (which == 2 && board_rst && bp_sysrst)) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #5;
      if (board_rst || bp_sysrst) seen++;
    end
  endtask

  initial begin
    int k, w, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 control after reset", 3'd1, 0);
    rd_chk("R1 rate after reset", 3'd2, 0);
    rd_chk("R1 reload low after reset", 3'd3, 8'hFF);
    rd_chk("R1 reload high after reset", 3'd4, 8'h03);
    chk("R1 board_rst low", board_rst, 0);
    chk("R1 bp_sysrst low", bp_sysrst, 0);

    // R2 reserved bits and unused addresses
    wr(3'd1, 8'hFC);
    rd_chk("R2 control reserved bits", 3'd1, 0);
    wr(3'd2, 8'hF3);
    rd_chk("R2 rate reserved bits", 3'd2, 8'h03);
    rd_chk("R2 kick reads zero", 3'd0, 0);
    rd_chk("R2 unused address", 3'd7, 0);

    // R9 disabled: us_tick running, no pulses
    tick_div = 2;
    quiet(300, s);
    chk("R9 disabled stays quiet", s, 0);

    // R5/R7 basic period: C=5, N=0, tick every 2 cycles
    wr(3'd3, 8'd5); wr(3'd4, 8'd0); wr(3'd2, 8'd0);
    wr(3'd1, 8'h01);
    wait_pulse(0, 200, k, w);
    wait_pulse(0, 200, k, w);
    chk("R5 gap N=0", k, 10);
    chk("R7 no backplane pulse when target=0", w, 0);
    @(negedge clk); #5;
    chk("R6 pulse lasts one cycle", board_rst, 0);

    // R5 rate change
    wr(3'd2, 8'd2);
    wait_pulse(0, 400, k, w);
    wait_pulse(0, 400, k, w);
    chk("R5 gap N=2", k, 40);

    // R7 backplane target
    wr(3'd1, 8'h03);
    wait_pulse(1, 400, k, w);
    wait_pulse(1, 400, k, w);
    chk("R7 backplane gap", k, 40);
    chk("R7 board stays low when target=1", w, 0);

    // R8 system controller mirrors local reset
    sys_ctrl = 1'b1;
    wr(3'd1, 8'h01);
    wait_pulse(2, 400, k, w);
    wait_pulse(2, 400, k, w);
    chk("R8 both outputs together", k, 40);
    sys_ctrl = 1'b0;

    // R4 kicks hold off timeout, data ignored
    s = 0;
    for (int i = 0; i < 15; i++) begin
      int q;
      wr(3'd0, 8'(i * 37));
      quiet(18, q);
      s += q;
    end
    chk("R4 kicks keep outputs low", s, 0);

    // R9 disable mid-run, change reload while idle
    wr(3'd1, 8'h00);
    wr(3'd3, 8'd3);
    quiet(300, s);
    chk("R9 disabled mid-run stays quiet", s, 0);

    // R3 arming loads reload: tick every cycle, N=0, C=3
    tick_div = 1;
    wr(3'd2, 8'd0);
    repeat (4) @(negedge clk);
    wr(3'd1, 8'h01);
    wait_pulse(0, 50, k, w);
    chk("R3 first pulse after arming", k, 3);

    // R10 kick on the terminal edge
    @(negedge clk);
    wr(3'd0, 8'hA5);
    wait_pulse(0, 50, k, w);
    chk("R10 kick on terminal edge reloads", k, 3);

    // R6 zero reload: timeout on every step
    tick_div = 3;
    wr(3'd3, 8'd0);
    wait_pulse(0, 100, k, w);
    wait_pulse(0, 100, k, w);
    wait_pulse(0, 100, k, w);
    chk("R6 reload zero gap", k, 3);

    // R9 reload written while running waits for next load
    wr(3'd3, 8'd4);
    wait_pulse(0, 100, k, w);
    wait_pulse(0, 100, k, w);
    chk("R9 new reload used after load", k, 12);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule